// File: doc/BRIEF.md
# Ping-Pong Peripheral DMA Channel

This block is one DMA channel that moves bytes between memory and a peripheral, using two buffer descriptors in turn. Each descriptor holds a base address, a byte count and a read-only current address. Software writes the descriptors and a control word through a word-indexed register port. The channel emits one byte beat per cycle on a simple memory request port. A beat happens when the peripheral asks for data and memory accepts it.

A three-state buffer machine tracks the descriptors. It is idle with no buffer, running one buffer, or running one buffer with the other queued behind it. When the running buffer empties and the other one is queued, the channel switches to it on the next cycle without a gap. It then flags that software should refill the pair just released, and a status bit says which pair that is. When the last queued buffer empties, the channel stalls. A peripheral error is either counted as an interrupt or ignored. When it arrives while a buffer is queued, a control bit can make it stop the channel and turn the enable off.

Top module: `pp_dma_chan`

## Requirements
- R1: After reset every register reads 0, the buffer state is idle (00), `irq` is 0 and `mem_req` is 0.
- R2: Register indices: 0 control, 1 interrupt, 2 status, 3 bytes left. Pair p uses index 4+4p for the 16-bit count, 5+4p for the base address and 6+4p for the current address. Control bits: 0 stall-interrupt enable, 1 refill-interrupt enable, 3 error-interrupt enable, 4 channel enable, 5 abort-on-error, 6 ignore errors.
- R3: While enabled, writing a nonzero count to the free pair arms that pair and copies its base into its current address. From idle the state moves to running (01) and bytes-left takes the written count. From running it moves to queued (10). Writing a zero count arms nothing.
- R4: `mem_req` is 1 exactly when the channel is enabled, not idle, and `per_req` is 1. A beat needs `mem_ack` as well. Each beat adds 1 to the active pair's current address, which drives `mem_addr`, and subtracts 1 from bytes-left.
- R5: The last beat of a buffer in the queued state makes the other pair active in the next cycle. Bytes-left then takes that pair's count, the state becomes running, and both the refill status bit and the refill interrupt are set.
- R6: The last beat of a buffer in the running state makes the state idle and sets both the stall status bit and the stall interrupt. Beats stop.
- R7: Status word: bit 0 stall, bit 1 refill pending, bit 3 error pending, bits 5:4 buffer state, bit 6 free pair. The free pair is the active pair when idle and the other pair otherwise. Arming a pair clears the stall and refill bits.
- R8: `per_err` while enabled and not idle sets the error interrupt when ignore-errors is 0. When ignore-errors is 1 it has no effect.
- R9: When a counted error arrives in the queued state with abort-on-error 1, the state becomes idle, bytes-left becomes 0, the stall bit and stall interrupt are set, and control bit 4 clears. With abort-on-error 0 the state does not change.
- R10: Interrupt register bits: 0 stall, 1 refill, 3 error. Any write to it clears all of them, but an event in the same cycle wins. `irq` is the OR of each pending bit ANDed with its enable.
- R11: In the cycle after control bit 4 is seen at 0, the state is idle and bytes-left is 0. Counts, bases, current addresses, the active pair and the stall and refill status bits keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 4 | Register word index for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_idx` (combinational) |
| per_req | input | 1 | Peripheral wants a byte moved |
| per_err | input | 1 | Peripheral reports an error |
| mem_req | output | 1 | Byte beat request |
| mem_addr | output | AW | Address of the requested byte |
| mem_ack | input | 1 | Memory accepts the beat |
| irq | output | 1 | Channel interrupt |

## Verification
The assertions assume that software never rewrites the count of a pair that is already queued. The bench keeps to this, and the swap check depends on it. The assertions also assume that `reg_idx` stays stable while a write is strobed. The stimulus changes inputs only on falling edges. It writes one register per cycle and never arms a pair in the same cycle that the running buffer empties.

// File: rtl/pp_dma_pkg.sv
package pp_dma_pkg;

    localparam int unsigned NPAIR = 2;

    typedef enum logic [1:0] {
        BUF_IDLE   = 2'b00,
        BUF_RUN    = 2'b01,
        BUF_QUEUED = 2'b10
    } buf_state_e;

    localparam logic [3:0] IDX_CTRL = 4'd0;
    localparam logic [3:0] IDX_INT  = 4'd1;
    localparam logic [3:0] IDX_STAT = 4'd2;
    localparam logic [3:0] IDX_LEFT = 4'd3;
    localparam int unsigned PAIR_IDX0   = 4;
    localparam int unsigned PAIR_STRIDE = 4;

    typedef struct packed {
        logic ice;
        logic abort;
        logic en;
        logic err_ie;
        logic nfb_ie;
        logic stall_ie;
    } ctrl_t;

endpackage

// File: rtl/pp_dma_desc.sv
module pp_dma_desc #(
    parameter int unsigned AW = 32,
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_cnt,
    input  logic          wr_base,
    input  logic [31:0]   wdata,
    input  logic          load_cur,
    input  logic          adv,
    output logic [CW-1:0] cnt_o,
    output logic [AW-1:0] base_o,
    output logic [AW-1:0] cur_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [AW-1:0] base;
        logic [AW-1:0] cur;
    } desc_t;

    desc_t q, d;

    always_comb begin
        d = q;
        if (wr_cnt)  d.cnt  = wdata[CW-1:0];
        if (wr_base) d.base = wdata[AW-1:0];
        if (load_cur)  d.cur = q.base;
        else if (adv)  d.cur = q.cur + AW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cnt_o  = q.cnt;
    assign base_o = q.base;
    assign cur_o  = q.cur;
endmodule

// File: rtl/pp_dma_irq.sv
module pp_dma_irq (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       ev_stall,
    input  logic       ev_nfb,
    input  logic       ev_err,
    input  logic       ie_stall,
    input  logic       ie_nfb,
    input  logic       ie_err,
    output logic [2:0] pend_o,
    output logic       irq
);
    logic [2:0] pend_q, pend_d;

    always_comb begin
        pend_d = clr ? 3'b000 : pend_q;
        pend_d = pend_d | {ev_err, ev_nfb, ev_stall};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pend_o = pend_q;
    assign irq    = |(pend_q & {ie_err, ie_nfb, ie_stall});
endmodule

// File: rtl/pp_dma_fsm.sv
module pp_dma_fsm
    import pp_dma_pkg::*;
#(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          abort,
    input  logic          ice,
    input  logic [1:0]    cnt_wr,
    input  logic [CW-1:0] wcnt,
    input  logic [CW-1:0] cnt0,
    input  logic [CW-1:0] cnt1,
    input  logic          per_req,
    input  logic          mem_ack,
    input  logic          per_err,
    output buf_state_e    state,
    output logic          act,
    output logic          free_pair,
    output logic [CW-1:0] remain,
    output logic          stall_flag,
    output logic          nfb_flag,
    output logic          ev_stall,
    output logic          ev_nfb,
    output logic          ev_err,
    output logic [1:0]    load_cur,
    output logic [1:0]    adv,
    output logic          kill_en,
    output logic          mem_req
);
    typedef struct packed {
        buf_state_e    st;
        logic          act;
        logic [CW-1:0] left;
        logic          stall;
        logic          nfb;
    } fsm_t;

    fsm_t q, d;
    logic beat, last, arm, err_hit;

    always_comb begin
        d         = q;
        ev_stall  = 1'b0;
        ev_nfb    = 1'b0;
        ev_err    = 1'b0;
        load_cur  = '0;
        adv       = '0;
        kill_en   = 1'b0;
        free_pair = (q.st == BUF_IDLE) ? q.act : ~q.act;
        mem_req   = en && (q.st != BUF_IDLE) && per_req;
        beat      = mem_req && mem_ack;
        last      = beat && (q.left == CW'(1));
        arm       = en && (q.st != BUF_QUEUED) && cnt_wr[free_pair] && (wcnt != '0);
        err_hit   = en && (q.st != BUF_IDLE) && per_err && !ice;

        if (!en) begin
            d.st   = BUF_IDLE;
            d.left = '0;
        end else begin
            if (beat) begin
                d.left      = q.left - CW'(1);
                adv[q.act]  = 1'b1;
            end
            unique case (q.st)
                BUF_IDLE: begin
                    if (arm) begin
                        d.st             = BUF_RUN;
                        d.left           = wcnt;
                        load_cur[q.act]  = 1'b1;
                        d.stall          = 1'b0;
                        d.nfb            = 1'b0;
                    end
                end
                BUF_RUN: begin
                    if (arm && !last) begin
                        d.st              = BUF_QUEUED;
                        load_cur[~q.act]  = 1'b1;
                        d.stall           = 1'b0;
                        d.nfb             = 1'b0;
                    end else if (arm) begin
                        d.act             = ~q.act;
                        d.left            = wcnt;
                        load_cur[~q.act]  = 1'b1;
                        d.nfb             = 1'b1;
                        ev_nfb            = 1'b1;
                    end else if (last) begin
                        d.st     = BUF_IDLE;
                        d.stall  = 1'b1;
                        ev_stall = 1'b1;
                    end
                end
                BUF_QUEUED: begin
                    if (last) begin
                        d.act  = ~q.act;
                        d.left = q.act ? cnt0 : cnt1;
                        d.st   = BUF_RUN;
                        d.nfb  = 1'b1;
                        ev_nfb = 1'b1;
                    end
                end
                default: d.st = BUF_IDLE;
            endcase
            if (err_hit) begin
                ev_err = 1'b1;
                if (q.st == BUF_QUEUED && abort) begin
                    d.st     = BUF_IDLE;
                    d.left   = '0;
                    d.act    = q.act;
                    d.nfb    = q.nfb;
                    d.stall  = 1'b1;
                    ev_nfb   = 1'b0;
                    ev_stall = 1'b1;
                    kill_en  = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: BUF_IDLE, act: 1'b0, left: '0, stall: 1'b0, nfb: 1'b0};
        else        q <= d;
    end

    assign state      = q.st;
    assign act        = q.act;
    assign remain     = q.left;
    assign stall_flag = q.stall;
    assign nfb_flag   = q.nfb;
endmodule

// File: rtl/pp_dma_chan.sv
module pp_dma_chan
    import pp_dma_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [3:0]    reg_idx,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic          per_req,
    input  logic          per_err,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_ack,
    output logic          irq
);
    ctrl_t         ctrl_q, ctrl_d;
    buf_state_e    state;
    logic          act, free_pair, stall_flag, nfb_flag;
    logic          ev_stall, ev_nfb, ev_err, kill_en, int_clr;
    logic [CW-1:0] remain;
    logic [1:0]    load_cur, adv, cnt_wr, base_wr;
    logic [2:0]    pend;
    logic [CW-1:0] cnt_w  [NPAIR];
    logic [AW-1:0] base_w [NPAIR];
    logic [AW-1:0] cur_w  [NPAIR];

    always_comb begin
        ctrl_d = ctrl_q;
        if (reg_we && reg_idx == IDX_CTRL) begin
            ctrl_d.stall_ie = reg_wdata[0];
            ctrl_d.nfb_ie   = reg_wdata[1];
            ctrl_d.err_ie   = reg_wdata[3];
            ctrl_d.en       = reg_wdata[4];
            ctrl_d.abort    = reg_wdata[5];
            ctrl_d.ice      = reg_wdata[6];
        end
        if (kill_en) ctrl_d.en = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign int_clr = reg_we && (reg_idx == IDX_INT);

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        localparam logic [3:0] PIDX = 4'(PAIR_IDX0 + PAIR_STRIDE * p);
        assign cnt_wr[p]  = reg_we && (reg_idx == PIDX);
        assign base_wr[p] = reg_we && (reg_idx == PIDX + 4'd1);
        pp_dma_desc #(.AW(AW), .CW(CW)) u_desc (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_cnt   (cnt_wr[p]),
            .wr_base  (base_wr[p]),
            .wdata    (reg_wdata),
            .load_cur (load_cur[p]),
            .adv      (adv[p]),
            .cnt_o    (cnt_w[p]),
            .base_o   (base_w[p]),
            .cur_o    (cur_w[p])
        );
    end

    pp_dma_fsm #(.CW(CW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (ctrl_q.en),
        .abort      (ctrl_q.abort),
        .ice        (ctrl_q.ice),
        .cnt_wr     (cnt_wr),
        .wcnt       (reg_wdata[CW-1:0]),
        .cnt0       (cnt_w[0]),
        .cnt1       (cnt_w[1]),
        .per_req    (per_req),
        .mem_ack    (mem_ack),
        .per_err    (per_err),
        .state      (state),
        .act        (act),
        .free_pair  (free_pair),
        .remain     (remain),
        .stall_flag (stall_flag),
        .nfb_flag   (nfb_flag),
        .ev_stall   (ev_stall),
        .ev_nfb     (ev_nfb),
        .ev_err     (ev_err),
        .load_cur   (load_cur),
        .adv        (adv),
        .kill_en    (kill_en),
        .mem_req    (mem_req)
    );

    pp_dma_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (int_clr),
        .ev_stall (ev_stall),
        .ev_nfb   (ev_nfb),
        .ev_err   (ev_err),
        .ie_stall (ctrl_q.stall_ie),
        .ie_nfb   (ctrl_q.nfb_ie),
        .ie_err   (ctrl_q.err_ie),
        .pend_o   (pend),
        .irq      (irq)
    );

    assign mem_addr = cur_w[act];

    always_comb begin
        reg_rdata = '0;
        unique case (reg_idx)
            IDX_CTRL: reg_rdata = {25'd0, ctrl_q.ice, ctrl_q.abort, ctrl_q.en,
                                   ctrl_q.err_ie, 1'b0, ctrl_q.nfb_ie, ctrl_q.stall_ie};
            IDX_INT:  reg_rdata = {28'd0, pend[2], 1'b0, pend[1], pend[0]};
            IDX_STAT: reg_rdata = {25'd0, free_pair, state, pend[2], 1'b0,
                                   nfb_flag, stall_flag};
            IDX_LEFT: reg_rdata = 32'(remain);
            default: begin
                for (int p = 0; p < NPAIR; p++) begin
                    if (reg_idx == 4'(PAIR_IDX0 + PAIR_STRIDE * p))      reg_rdata = 32'(cnt_w[p]);
                    if (reg_idx == 4'(PAIR_IDX0 + PAIR_STRIDE * p + 1))  reg_rdata = 32'(base_w[p]);
                    if (reg_idx == 4'(PAIR_IDX0 + PAIR_STRIDE * p + 2))  reg_rdata = 32'(cur_w[p]);
                end
            end
        endcase
    end
endmodule

// File: rtl/pp_dma_chk.sv
module pp_dma_chk
    import pp_dma_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_we,
    input logic [3:0]    reg_idx,
    input logic          per_err,
    input logic          mem_req,
    input logic          mem_ack,
    input logic [AW-1:0] mem_addr,
    input logic          irq,
    input buf_state_e    state,
    input logic          act,
    input logic [CW-1:0] remain,
    input logic          stall_flag,
    input ctrl_t         ctrl_q,
    input logic          ev_stall,
    input logic          ev_nfb,
    input logic          ev_err
);
    // R4: a beat that is not the last one steps the address by one
    a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && remain > CW'(1)) |=> (mem_addr == $past(mem_addr) + AW'(1)));

    // R5: last beat while queued hands over to the other pair
    a_r5_swap_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (state == BUF_QUEUED && mem_req && mem_ack && remain == CW'(1)
         && !(per_err && ctrl_q.abort && !ctrl_q.ice))
        |=> (state == BUF_RUN && act != $past(act)));

    // R6: entering stall with the stall enable set raises the interrupt at once
    a_r6_stall_irq: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(stall_flag) && ctrl_q.stall_ie) |-> irq);

    // R9: counted error while queued with abort set stops and disables
    a_r9_abort_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.en && state == BUF_QUEUED && per_err && ctrl_q.abort && !ctrl_q.ice)
        |=> (!ctrl_q.en && state == BUF_IDLE && stall_flag));

    // R10: clearing with no event in the same cycle leaves the interrupt low
    a_r10_clear_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_idx == IDX_INT && !ev_stall && !ev_nfb && !ev_err) |=> !irq);

    // R11: a disabled channel is idle with nothing left one cycle later
    a_r11_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q.en |=> (state == BUF_IDLE && remain == '0));
endmodule

bind pp_dma_chan pp_dma_chk #(.AW(AW), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_idx    (reg_idx),
    .per_err    (per_err),
    .mem_req    (mem_req),
    .mem_ack    (mem_ack),
    .mem_addr   (mem_addr),
    .irq        (irq),
    .state      (state),
    .act        (act),
    .remain     (remain),
    .stall_flag (stall_flag),
    .ctrl_q     (ctrl_q),
    .ev_stall   (ev_stall),
    .ev_nfb     (ev_nfb),
    .ev_err     (ev_err)
);

// File: tb/pp_dma_chan_tb.sv
`timescale 1ns/1ps
module pp_dma_chan_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_idx = 4'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        per_req = 1'b0, per_err = 1'b0, mem_ack = 1'b0;
    logic        mem_req, irq;
    logic [31:0] mem_addr;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    pp_dma_chan u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .per_req(per_req),
        .per_err(per_err), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .irq(irq)
    );

    typedef struct packed {
        logic        we;
        logic [3:0]  idx;
        logic [31:0] wd;
        logic        preq;
        logic        ack;
        logic        perr;
        logic [3:0]  cidx;
        logic [31:0] cval;
        logic        cirq;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 44;
    // idx: 0 ctrl, 1 int, 2 stat, 3 left, 4/5/6 pair0 cnt/base/cur, 8/9/10 pair1
    localparam vec_t VEC [NV] = '{
        '{1'b1, 4'd0, 32'h1B,   1'b0,1'b0,1'b0, 4'd0,  32'h1B,   1'b0, 8'd2},  // R2 ctrl bits
        '{1'b1, 4'd5, 32'h1000, 1'b0,1'b0,1'b0, 4'd5,  32'h1000, 1'b0, 8'd2},
        '{1'b1, 4'd4, 32'd3,    1'b0,1'b0,1'b0, 4'd2,  32'h50,   1'b0, 8'd3},  // R3 idle->run
        '{1'b0, 4'd0, 32'd0,    1'b0,1'b0,1'b0, 4'd3,  32'd3,    1'b0, 8'd3},
        '{1'b0, 4'd0, 32'd0,    1'b1,1'b1,1'b0, 4'd6,  32'h1001, 1'b0, 8'd4},  // R4 beat
        '{1'b0, 4'd0, 32'd0,    1'b1,1'b0,1'b0, 4'd3,  32'd2,    1'b0, 8'd4},  // no ack
        '{1'b0, 4'd0, 32'd0,    1'b0,1'b1,1'b0, 4'd6,  32'h1001, 1'b0, 8'd4},  // no req
        '{1'b1, 4'd9, 32'h2000, 1'b0,1'b0,1'b0, 4'd2,  32'h50,   1'b0, 8'd7},
        '{1'b1, 4'd8, 32'd2,    1'b0,1'b0,1'b0, 4'd2,  32'h60,   1'b0, 8'd3},  // R3 run->queued
        '{1'b0, 4'd0, 32'd0,    1'b1,1'b1,1'b0, 4'd3,  32'd1,    1'b0, 8'd4},
        '{1'b0, 4'd0, 32'd0,    1'b1,1'b1,1'b0, 4'd2,  32'h12,   1'b1, 8'd5},  // R5 swap
        '{1'b0, 4'd0, 32'd0,    1'b0,1'b0,1'b0, 4'd1,  32'h02,   1'b1, 8'd10},
        '{1'b1, 4'd1, 32'd0,    1'b0,1'b0,1'b0, 4'd1,  32'h00,   1'b0, 8'd10}, // R10 clear
        '{1'b0, 4'd0, 32'd0,    1'b0,1'b0,1'b0, 4'd2,  32'h12,   1'b0, 8'd7},
        '{1'b0, 4'd0, 32'd0,    1'b1,1'b1,1'b0, 4'd10, 32'h2001, 1'b0, 8'd5},
        '{1'b0, 4'd0, 32'd0,    1'b1,1'b1,1'b0, 4'd2,  32'h43,   1'b1, 8'd6},  // R6 stall
        '{1'b0, 4'd0, 32'd0,    1'b0,1'b0,1'b0, 4'd1,  32'h01,   1'b1, 8'd6},
        '{1'b0, 4'd0, 32'd0,    1'b1,1'b1,1'b0, 4'd10, 32'h2002, 1'b1, 8'd6},
        '{1'b1, 4'd1, 32'h0,    1'b0,1'b0,1'b0, 4'd1,  32'h00,   1'b0, 8'd10},
        '{1'b1, 4'd8, 32'd1,    1'b0,1'b0,1'b0, 4'd2,  32'h10,   1'b0, 8'd7},  // R7 arm clears flags
        '{1'b0, 4'd0, 32'd0,    1'b0,1'b0,1'b1, 4'd1,  32'h08,   1'b1, 8'd8},  // R8 error
        '{1'b1, 4'd1, 32'd0,    1'b0,1'b0,1'b0, 4'd1,  32'h00,   1'b0, 8'd10},
        '{1'b1, 4'd0, 32'h5B,   1'b0,1'b0,1'b0, 4'd0,  32'h5B,   1'b0, 8'd2},
        '{1'b0, 4'd0, 32'd0,    1'b0,1'b0,1'b1, 4'd1,  32'h00,   1'b0, 8'd8},  // R8 ignored
        '{1'b1, 4'd0, 32'h3B,   1'b0,1'b0,1'b0, 4'd0,  32'h3B,   1'b0, 8'd2},
        '{1'b1, 4'd4, 32'd4,    1'b0,1'b0,1'b0, 4'd2,  32'h20,   1'b0, 8'd3},
        '{1'b0, 4'd0, 32'd0,    1'b0,1'b0,1'b1, 4'd0,  32'h2B,   1'b1, 8'd9},  // R9 abort
        '{1'b0, 4'd0, 32'd0,    1'b0,1'b0,1'b0, 4'd1,  32'h09,   1'b1, 8'd9},
        '{1'b0, 4'd0, 32'd0,    1'b0,1'b0,1'b0, 4'd2,  32'h49,   1'b1, 8'd9},
        '{1'b0, 4'd0, 32'd0,    1'b0,1'b0,1'b0, 4'd3,  32'd0,    1'b1, 8'd9},
        '{1'b1, 4'd1, 32'd0,    1'b0,1'b0,1'b0, 4'd1,  32'h00,   1'b0, 8'd10},
        '{1'b1, 4'd0, 32'h1B,   1'b0,1'b0,1'b0, 4'd0,  32'h1B,   1'b0, 8'd2},
        '{1'b1, 4'd8, 32'd2,    1'b0,1'b0,1'b0, 4'd2,  32'h10,   1'b0, 8'd3},
        '{1'b1, 4'd4, 32'd1,    1'b0,1'b0,1'b0, 4'd2,  32'h20,   1'b0, 8'd3},
        '{1'b0, 4'd0, 32'd0,    1'b0,1'b0,1'b1, 4'd2,  32'h28,   1'b1, 8'd9},  // R9 no abort
        '{1'b1, 4'd1, 32'd0,    1'b0,1'b0,1'b0, 4'd1,  32'h00,   1'b0, 8'd10},
        '{1'b1, 4'd0, 32'h0B,   1'b0,1'b0,1'b0, 4'd0,  32'h0B,   1'b0, 8'd11}, // R11 disable
        '{1'b0, 4'd0, 32'd0,    1'b0,1'b0,1'b0, 4'd2,  32'h40,   1'b0, 8'd11},
        '{1'b0, 4'd0, 32'd0,    1'b0,1'b0,1'b0, 4'd3,  32'd0,    1'b0, 8'd11},
        '{1'b0, 4'd0, 32'd0,    1'b0,1'b0,1'b0, 4'd9,  32'h2000, 1'b0, 8'd11},
        '{1'b0, 4'd0, 32'd0,    1'b0,1'b0,1'b0, 4'd8,  32'd2,    1'b0, 8'd11},
        '{1'b1, 4'd0, 32'h1B,   1'b0,1'b0,1'b0, 4'd0,  32'h1B,   1'b0, 8'd2},
        '{1'b1, 4'd8, 32'd0,    1'b0,1'b0,1'b0, 4'd2,  32'h40,   1'b0, 8'd3},  // R3 zero count
        '{1'b0, 4'd0, 32'd0,    1'b0,1'b0,1'b0, 4'd8,  32'd0,    1'b0, 8'd3}
    };

    task automatic check(input int req, input string what, input logic [31:0] act_v,
                         input logic [31:0] exp_v);
        n_chk++;
        if (act_v !== exp_v) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act_v, exp_v);
        end
    endtask

    task automatic read_chk(input int req, input logic [3:0] idx, input logic [31:0] exp_v);
        reg_idx = idx;
        #0.5;
        check(req, $sformatf("reg %0d", idx), reg_rdata, exp_v);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        read_chk(1, 4'd0, 32'd0);
        read_chk(1, 4'd2, 32'd0);
        read_chk(1, 4'd3, 32'd0);
        check(1, "irq in reset", {31'd0, irq}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        read_chk(1, 4'd1, 32'd0);
        read_chk(1, 4'd6, 32'd0);
        check(1, "mem_req after reset", {31'd0, mem_req}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            reg_we    = VEC[i].we;
            reg_idx   = VEC[i].idx;
            reg_wdata = VEC[i].wd;
            per_req   = VEC[i].preq;
            mem_ack   = VEC[i].ack;
            per_err   = VEC[i].perr;
            @(posedge clk);
            #1;
            reg_we = 1'b0; per_req = 1'b0; mem_ack = 1'b0; per_err = 1'b0;
            read_chk(int'(VEC[i].req), VEC[i].cidx, VEC[i].cval);
            check(int'(VEC[i].req), $sformatf("irq vec %0d", i), {31'd0, irq}, {31'd0, VEC[i].cirq});
        end

        // R4: request and address at the port once a pair is armed
        @(negedge clk);
        reg_we = 1'b1; reg_idx = 4'd8; reg_wdata = 32'd5;
        @(negedge clk);
        reg_we = 1'b0;
        per_req = 1'b1;
        #0.5;
        check(4, "mem_req with per_req", {31'd0, mem_req}, 32'd1);
        check(4, "mem_addr", mem_addr, 32'h2000);
        per_req = 1'b0;
        #0.5;
        check(4, "mem_req without per_req", {31'd0, mem_req}, 32'd0);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule